// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel data buses, A and B, and carries data between them in either direction. Each direction has its own holding register with its own capture clock: the A-to-B register samples the A bus, and the B-to-A register samples the B bus. When a bus is driven, a per-direction select chooses its source. The source is either the live value on the opposite bus, which passes through combinationally, or the value held in that direction's register.

An active-low enable and a direction input decide which bus is driven, if either is. Every bus has a separate input vector, output vector and output-enable bit, so the block needs no tri-state logic inside it. The surrounding pad logic combines these into a real bidirectional bus. Capture into either register never depends on the enable or direction inputs. This means a bus can be sampled and held while both sides are isolated, and the held value can be replayed later.

Top module: `regxcvr_top`

## Requirements
- R1: An asynchronous active-low reset clears both holding registers to zero, so a stored-mode read just after reset returns zero.
- R2: On each rising edge of `clk_ab`, the A-to-B register loads the value on `a_in`.
- R3: On each rising edge of `clk_ba`, the B-to-A register loads the value on `b_in`.
- R4: Capture into either register happens for every value of `oe_n` and `dir`, including isolation.
- R5: When `oe_n` is 1 (isolation), `a_oe` and `b_oe` are both 0.
- R6: When `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0; bus A is driven.
- R7: When `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0; bus B is driven.
- R8: While bus A is driven and `sel_ba` is 0, `a_out` equals the current `b_in` with no clock in the path.
- R9: While bus A is driven and `sel_ba` is 1, `a_out` equals the B-to-A register.
- R10: While bus B is driven, `b_out` equals the current `a_in` if `sel_ab` is 0, or the A-to-B register if `sel_ab` is 1.
- R11: When both clocks rise together, both registers load in that same edge.
- R12: `a_oe` and `b_oe` are never 1 at the same time.
- R13: An output whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| oe_n | input | 1 | Active-low output enable for the whole block |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A |
| a_in | input | W | Value sensed on bus A |
| a_out | output | W | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value sensed on bus B |
| b_out | output | W | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds the block with the default width of 8. At that width, random words cover all-zero, all-ones and mixed patterns, and the live value and the stored value of a direction almost always differ. That difference makes a wrong source selection show up on the output. Directed steps cover reset, capture in isolation, and both clocks rising together. A random loop then sweeps every combination of enable, direction and select, with random clock patterns, against a reference model.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

endpackage

// File: rtl/regxcvr_hold.sv
module regxcvr_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] val_d;
    logic [W-1:0] val_q;

    // Capture is unconditional: every rising edge samples the bus.
    always_comb begin
        val_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign dout = val_q;

endmodule

// File: rtl/regxcvr_route.sv
module regxcvr_route
    import regxcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] ab_q,
    input  logic [W-1:0] ba_q,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    drive_e       drv;
    logic [W-1:0] to_a;
    logic [W-1:0] to_b;

    always_comb begin
        if (oe_n) begin
            drv = DRV_NONE;
        end else if (dir) begin
            drv = DRV_B;
        end else begin
            drv = DRV_A;
        end
    end

    always_comb begin
        to_a = sel_ba ? ba_q : b_in;
        to_b = sel_ab ? ab_q : a_in;
    end

    always_comb begin
        a_oe  = (drv == DRV_A);
        b_oe  = (drv == DRV_B);
        a_out = a_oe ? to_a : '0;
        b_out = b_oe ? to_b : '0;
    end

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;

    regxcvr_hold #(.W(W)) u_hold_ab (
        .clk  (clk_ab),
        .rst_n(rst_n),
        .din  (a_in),
        .dout (ab_q)
    );

    regxcvr_hold #(.W(W)) u_hold_ba (
        .clk  (clk_ba),
        .rst_n(rst_n),
        .din  (b_in),
        .dout (ba_q)
    );

    regxcvr_route #(.W(W)) u_route (
        .oe_n  (oe_n),
        .dir   (dir),
        .sel_ab(sel_ab),
        .sel_ba(sel_ba),
        .a_in  (a_in),
        .b_in  (b_in),
        .ab_q  (ab_q),
        .ba_q  (ba_q),
        .a_out (a_out),
        .a_oe  (a_oe),
        .b_out (b_out),
        .b_oe  (b_oe)
    );

endmodule

// File: rtl/regxcvr_chk.sv
module regxcvr_chk #(
    parameter int W = 8
) (
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] ab_q,
    input logic [W-1:0] ba_q
);

    p_load_ab_r2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        1'b1 |=> (ab_q == $past(a_in)));

    p_load_ba_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
        1'b1 |=> (ba_q == $past(b_in)));

    p_isolate_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));

    p_drive_a_r6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && !dir) |-> (a_oe && !b_oe));

    p_drive_b_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && dir) |-> (b_oe && !a_oe));

    p_live_a_r8: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> (a_out == b_in));

    p_stored_a_r9: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (a_oe && sel_ba) |-> (a_out == ba_q));

    p_src_b_r10: assert property (@(posedge clk_ab) disable iff (!rst_n)
        b_oe |-> (b_out == (sel_ab ? ab_q : a_in)));

    p_excl_r12: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !(a_oe && b_oe));

    p_quiet_r13: assert property (@(posedge clk_ba) disable iff (!rst_n)
        ((!a_oe) |-> (a_out == '0)) and ((!b_oe) |-> (b_out == '0)));

endmodule

bind regxcvr_top regxcvr_chk #(.W(W)) u_chk (
    .rst_n (rst_n),
    .clk_ab(clk_ab),
    .clk_ba(clk_ba),
    .oe_n  (oe_n),
    .dir   (dir),
    .sel_ab(sel_ab),
    .sel_ba(sel_ba),
    .a_in  (a_in),
    .b_in  (b_in),
    .a_out (a_out),
    .a_oe  (a_oe),
    .b_out (b_out),
    .b_oe  (b_oe),
    .ab_q  (ab_q),
    .ba_q  (ba_q)
);

// File: tb/tb_regxcvr_top.sv
module tb_regxcvr_top;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;

    logic         rst_n;
    logic         clk_ab;
    logic         clk_ba;
    logic         oe_n;
    logic         dir;
    logic         sel_ab;
    logic         sel_ba;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    logic [W-1:0] m_ab;
    logic [W-1:0] m_ba;
    int           checks;
    int           errors;

    regxcvr_top #(.W(W)) dut (
        .rst_n (rst_n),
        .clk_ab(clk_ab),
        .clk_ba(clk_ba),
        .oe_n  (oe_n),
        .dir   (dir),
        .sel_ab(sel_ab),
        .sel_ba(sel_ba),
        .a_in  (a_in),
        .a_out (a_out),
        .a_oe  (a_oe),
        .b_in  (b_in),
        .b_out (b_out),
        .b_oe  (b_oe)
    );

    function automatic logic exp_a_oe(logic o, logic d);
        return !o && !d;
    endfunction

    function automatic logic exp_b_oe(logic o, logic d);
        return !o && d;
    endfunction

    function automatic logic [W-1:0] exp_a_out(logic o, logic d, logic s,
                                                logic [W-1:0] live, logic [W-1:0] held);
        if (!exp_a_oe(o, d)) return '0;
        return s ? held : live;
    endfunction

    function automatic logic [W-1:0] exp_b_out(logic o, logic d, logic s,
                                                logic [W-1:0] live, logic [W-1:0] held);
        if (!exp_b_oe(o, d)) return '0;
        return s ? held : live;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model; tags name the covering requirements.
    task automatic check_all(string ctx);
        #1;
        check({ctx, " a_oe R5/R6/R7/R12"}, W'(a_oe), W'(exp_a_oe(oe_n, dir)));
        check({ctx, " b_oe R5/R6/R7/R12"}, W'(b_oe), W'(exp_b_oe(oe_n, dir)));
        check({ctx, " a_out R8/R9/R13"}, a_out, exp_a_out(oe_n, dir, sel_ba, b_in, m_ba));
        check({ctx, " b_out R10/R13"}, b_out, exp_b_out(oe_n, dir, sel_ab, a_in, m_ab));
    endtask

    task automatic pulse(logic do_ab, logic do_ba);
        #(CLK_PERIOD/2);
        clk_ab = do_ab;
        clk_ba = do_ba;
        if (do_ab) m_ab = a_in;
        if (do_ba) m_ba = b_in;
        #(CLK_PERIOD/2);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
    endtask

    task automatic set_ctl(logic o, logic d, logic sa, logic sb);
        oe_n   = o;
        dir    = d;
        sel_ab = sa;
        sel_ba = sb;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] seed_val;
        checks = 0;
        errors = 0;
        seed_val = W'($urandom(32'd1234));
        clk_ab = 0; clk_ba = 0; rst_n = 0;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        a_in = 8'h3c; b_in = 8'hc3;
        m_ab = '0; m_ba = '0;
        #(CLK_PERIOD);
        rst_n = 1;
        #(CLK_PERIOD);

        // R1: stored-mode reads right after reset return zero
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        #1; check("R1 b_out stored after reset", b_out, '0);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        #1; check("R1 a_out stored after reset", a_out, '0);

        // R5 and R13: isolation drives nothing
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        #1; check("R5 a_oe isolation", W'(a_oe), '0);
        check("R5 b_oe isolation", W'(b_oe), '0);
        check("R13 a_out isolation", a_out, '0);
        check("R13 b_out isolation", b_out, '0);

        // R4 with R2/R3: capture during isolation, then replay
        a_in = 8'ha5; b_in = 8'h5a;
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        a_in = 8'h00; b_in = 8'hff;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        #1; check("R4 R2 stored A-to-B replay", b_out, 8'ha5);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        #1; check("R4 R3 stored B-to-A replay", a_out, 8'h5a);

        // R8/R10: live path changes without any clock
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        b_in = 8'h81;
        #1; check("R8 live B to A", a_out, 8'h81);
        b_in = 8'h7e;
        #1; check("R8 live B to A follows", a_out, 8'h7e);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'h96;
        #1; check("R10 live A to B", b_out, 8'h96);

        // R11: both clocks rise together
        a_in = 8'h11; b_in = 8'hee;
        pulse(1'b1, 1'b1);
        a_in = 8'h22; b_in = 8'hdd;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        #1; check("R11 both load, A-to-B", b_out, 8'h11);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        #1; check("R11 both load, B-to-A", a_out, 8'hee);
        check("R12 exclusive drive", W'(a_oe & b_oe), '0);

        // R9: stored value held while live input changes
        b_in = 8'h00;
        #1; check("R9 stored B-to-A ignores live", a_out, 8'hee);

        // Random sweep of all control combinations and clock patterns
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] ctl;
            logic [1:0] clks;
            ctl  = 4'($urandom);
            clks = 2'($urandom);
            a_in = W'($urandom);
            b_in = W'($urandom) ^ seed_val;
            set_ctl(ctl[0], ctl[1], ctl[2], ctl[3]);
            pulse(clks[0], clks[1]);
            a_in = W'($urandom);
            b_in = W'($urandom);
            check_all("random R2/R3/R4/R11");
        end

        // Every control combination with fixed data, both stored and live differ
        for (int c = 0; c < 16; c++) begin
            set_ctl(c[0], c[1], c[2], c[3]);
            a_in = 8'h0f; b_in = 8'hf0;
            check_all("sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule